// File: doc/BRIEF.md
# Counter-Based Floppy Data Separator

This block turns the raw flux-transition pulses from a floppy read head into a serial stream of decoded data bits. The base clock is fixed and does not track the drive. A single counter runs from that clock and starts again at every flux pulse, so the spacing between two transitions is measured afresh each time. Each measured spacing is rounded to a whole number of nominal cells. In MFM mode the cell is half a data bit. The decoder then turns that cell count into zero, one or two data bits, based on whether the previous transition sat in a data slot or a clock slot.

A slow or fast spindle therefore shows up only as a small offset inside one interval. The offset is never carried into the next interval. The read input may be asynchronous and of any width. Intervals that the selected code cannot produce are reported on an error strobe and emit no bits. A window output shows whether the slot nearest to the current time, counted from the last transition, is a data slot or a clock slot. The mode select is assumed static between resets.

Top module: `dsep_data_separator`

## Requirements
- R1: A read pulse is counted once on its rising edge, whatever its length. An input held high for many cycles produces a single interval event.
- R2: An interval of t base-clock cycles between two pulse rises is rounded to n cells, where (n-0.5)*CELL_TICKS <= t < (n+0.5)*CELL_TICKS. Any t below 1.5 cells counts as n=1.
- R3: In MFM mode (mfm_sel=1) the decoding depends on the slot of the previous transition. After a data-slot transition: 2 cells emits 1; 3 cells emits 0 and moves to a clock slot; 4 cells emits 0 then 1. After a clock-slot transition: 2 cells emits 0; 3 cells emits 0 then 1 and moves to a data slot.
- R4: In FM mode (mfm_sel=0), after a clock-slot transition, 1 cell emits 1 and moves to a data slot, and 2 cells emits 0. After a data-slot transition, 1 cell emits nothing and returns to a clock slot.
- R5: The first pulse after reset only sets the reference and emits neither bits nor an error. That reference is a data slot in MFM and a clock slot in FM.
- R6: An interval of 4.5 cells or more in MFM, or 2.5 cells or more in FM, raises interval_err for one cycle and emits no bits.
- R7: Spacings the code forbids raise interval_err and emit no bits: under 1.5 cells in MFM, 4 cells after a clock slot in MFM, and 2 cells after a data slot in FM. After any error the pulse becomes a fresh reference with the reset slot kind of R5.
- R8: Bits decode correctly when the drive runs 10 % slow or fast (9 or 11 cycles per cell at the default of 10), because each pulse restarts the count.
- R9: Decoded bits leave oldest first, one per cycle, with dbit_valid high for at most two consecutive cycles.
- R10: data_window shows the slot kind of the last transition (1 = data slot) for the first CELL_TICKS/2 cycles after the pulse restarts the counter. It then flips every CELL_TICKS cycles.
- R11: While and right after reset, dbit_valid and interval_err are low, and data_window is 1 in MFM mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed base clock, about ten ticks per nominal cell |
| rst_n | input | 1 | Synchronous active-low reset |
| mfm_sel | input | 1 | 1 selects MFM decoding, 0 selects FM |
| rd_flux | input | 1 | Raw read pulses from the drive, asynchronous |
| dbit | output | 1 | Decoded data bit, meaningful when dbit_valid is high |
| dbit_valid | output | 1 | One-cycle strobe per decoded bit |
| data_window | output | 1 | 1 while the nearest slot is a data slot |
| interval_err | output | 1 | One-cycle strobe for an illegal or over-long interval |

## Verification
Random bit strings are encoded in MFM and FM and replayed as pulse trains with a jitter of up to two cycles per transition. The decoded stream is compared bit for bit, which exercises every cell count from every slot kind. The same strings replayed at nine and eleven cycles per cell show whether the phase error stays inside each interval or builds up. Directed trains probe the rounding thresholds one cycle on each side, each forbidden spacing, a very long gap followed by recovery, a wide input pulse and the FM case that emits no bit. These cases separate a wrong threshold, a wrong slot-kind update and a missed re-reference.

// File: rtl/dsep_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the data separator.
// Assumes at most four nominal cells between legal transitions.
package dsep_pkg;
    localparam int MAX_CELLS = 4;
    localparam int CELLS_W   = 3;
    typedef logic [CELLS_W-1:0] cells_t;
endpackage

// File: rtl/dsep_sync_edge.sv
`timescale 1ns/1ps
// Synchroniser and rising-edge detector for the raw read input.
// Assumes the input is asynchronous; pulse is one cycle wide per rise.
module dsep_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the input through the synchroniser and keep the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pulse = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R1: an edge never lasts more than one cycle
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/dsep_interval_counter.sv
`timescale 1ns/1ps
// Interval counter restarted by every pulse, plus the slot-parity tracker.
// Captures the tick count between pulses; saturates past the longest legal gap.
module dsep_interval_counter #(
    parameter int CELL_TICKS = 10,
    parameter int SAT        = 50,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    output logic [CNT_W-1:0] ivl_q,
    output logic             ivl_stb,
    output logic             slot_par
);
    localparam int HALF  = CELL_TICKS / 2;
    localparam int SUB_W = $clog2(CELL_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [SUB_W-1:0] sub_q;

    // Count ticks since the last pulse and capture the total at each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ivl_q   <= '0;
            ivl_stb <= 1'b0;
        end else begin
            ivl_stb <= pulse;
            if (pulse) begin
                ivl_q <= cnt_q;
                cnt_q <= CNT_W'(1);
            end else if (cnt_q != CNT_W'(SAT)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Track which nominal slot is nearest, flipping at each half-cell point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q    <= '0;
            slot_par <= 1'b0;
        end else if (pulse) begin
            sub_q    <= '0;
            slot_par <= 1'b0;
        end else begin
            sub_q <= (sub_q == SUB_W'(CELL_TICKS-1)) ? '0 : sub_q + 1'b1;
            if (sub_q == SUB_W'(HALF-1))
                slot_par <= ~slot_par;
        end
    end
endmodule

// File: rtl/dsep_cell_classifier.sv
`timescale 1ns/1ps
// Rounds a tick interval to a whole number of nominal cells.
// Thresholds lie halfway between cell counts; beyond MAX_CELLS+0.5 is over.
module dsep_cell_classifier
    import dsep_pkg::*;
#(
    parameter int CELL_TICKS = 10,
    parameter int CNT_W      = 6
) (
    input  logic [CNT_W-1:0] ivl,
    output cells_t           cells,
    output logic             over
);
    localparam int CMP_W = CNT_W + 2;

    logic [MAX_CELLS:1] below;
    logic [CMP_W-1:0]   twice;

    assign twice = {1'b0, ivl, 1'b0};

    // One comparator per cell count against its upper half-way threshold.
    for (genvar n = 1; n <= MAX_CELLS; n++) begin : g_thr
        assign below[n] = twice < CMP_W'((2*n+1)*CELL_TICKS);
    end

    // Pick the smallest cell count whose threshold is not reached.
    always_comb begin
        cells = '0;
        over  = 1'b1;
        for (int n = MAX_CELLS; n >= 1; n--) begin
            if (below[n]) begin
                cells = CELLS_W'(n);
                over  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsep_bit_decoder.sv
`timescale 1ns/1ps
// Turns classified intervals into data bits for MFM or FM.
// Tracks whether the last transition sat in a data or a clock slot.
// Assumes interval events are at least two cycles apart.
module dsep_bit_decoder
    import dsep_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mfm_sel,
    input  logic   ivl_stb,
    input  cells_t cells,
    input  logic   over,
    input  logic   slot_par,
    output logic   dbit,
    output logic   dbit_valid,
    output logic   data_window,
    output logic   interval_err
);
    logic armed_q, ref_data_q, pend_valid_q, pend_bit_q;
    logic bad;
    logic [1:0] n_emit;
    logic b0, b1, nxt_ref;

    // Decode table: bits to emit and next slot kind for this interval.
    always_comb begin
        bad     = 1'b0;
        n_emit  = 2'd0;
        b0      = 1'b0;
        b1      = 1'b0;
        nxt_ref = ref_data_q;
        if (over) begin
            bad = 1'b1;
        end else if (mfm_sel) begin
            if (ref_data_q) begin
                unique case (cells)
                    3'd2:    begin n_emit = 2'd1; b0 = 1'b1; nxt_ref = 1'b1; end
                    3'd3:    begin n_emit = 2'd1; b0 = 1'b0; nxt_ref = 1'b0; end
                    3'd4:    begin n_emit = 2'd2; b0 = 1'b0; b1 = 1'b1; nxt_ref = 1'b1; end
                    default: bad = 1'b1;
                endcase
            end else begin
                unique case (cells)
                    3'd2:    begin n_emit = 2'd1; b0 = 1'b0; nxt_ref = 1'b0; end
                    3'd3:    begin n_emit = 2'd2; b0 = 1'b0; b1 = 1'b1; nxt_ref = 1'b1; end
                    default: bad = 1'b1;
                endcase
            end
        end else begin
            if (!ref_data_q) begin
                unique case (cells)
                    3'd1:    begin n_emit = 2'd1; b0 = 1'b1; nxt_ref = 1'b1; end
                    3'd2:    begin n_emit = 2'd1; b0 = 1'b0; nxt_ref = 1'b0; end
                    default: bad = 1'b1;
                endcase
            end else begin
                if (cells == 3'd1) nxt_ref = 1'b0;
                else               bad = 1'b1;
            end
        end
    end

    // Register the outcome of each interval and drain a pending second bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q      <= 1'b0;
            ref_data_q   <= mfm_sel;
            pend_valid_q <= 1'b0;
            pend_bit_q   <= 1'b0;
            dbit         <= 1'b0;
            dbit_valid   <= 1'b0;
            interval_err <= 1'b0;
        end else begin
            dbit_valid   <= 1'b0;
            interval_err <= 1'b0;
            if (ivl_stb) begin
                if (!armed_q) begin
                    armed_q    <= 1'b1;
                    ref_data_q <= mfm_sel;
                end else if (bad) begin
                    interval_err <= 1'b1;
                    ref_data_q   <= mfm_sel;
                end else begin
                    dbit_valid   <= (n_emit != 2'd0);
                    dbit         <= b0;
                    pend_valid_q <= (n_emit == 2'd2);
                    pend_bit_q   <= b1;
                    ref_data_q   <= nxt_ref;
                end
            end else if (pend_valid_q) begin
                dbit_valid   <= 1'b1;
                dbit         <= pend_bit_q;
                pend_valid_q <= 1'b0;
            end
        end
    end

    assign data_window = ref_data_q ^ slot_par;

    // R5: the reference pulse emits nothing
    p_first_ref_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_stb && !armed_q) |=> (!dbit_valid && !interval_err));
    // R6: an over-long interval gives an error and no bit
    p_err_on_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_stb && over && armed_q) |=> (interval_err && !dbit_valid));
    // R9: a new interval never meets an undrained second bit
    p_no_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_stb |-> !pend_valid_q);
    // R9: bursts stop after two bits
    p_burst_max_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbit_valid && $past(dbit_valid)) |=> !dbit_valid);
endmodule

// File: rtl/dsep_data_separator.sv
`timescale 1ns/1ps
// Counter-based data separator: flux pulses in, decoded data bits out.
// Assumes a static mode between resets and CELL_TICKS of at least 4.
module dsep_data_separator
    import dsep_pkg::*;
#(
    parameter int CELL_TICKS  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mfm_sel,
    input  logic rd_flux,
    output logic dbit,
    output logic dbit_valid,
    output logic data_window,
    output logic interval_err
);
    localparam int SAT   = (MAX_CELLS + 1) * CELL_TICKS;
    localparam int CNT_W = $clog2(SAT + 1);

    logic             pulse;
    logic [CNT_W-1:0] ivl;
    logic             ivl_stb;
    logic             slot_par;
    cells_t           cells;
    logic             over;

    dsep_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_flux), .pulse(pulse)
    );

    dsep_interval_counter #(.CELL_TICKS(CELL_TICKS), .SAT(SAT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pulse(pulse),
        .ivl_q(ivl), .ivl_stb(ivl_stb), .slot_par(slot_par)
    );

    dsep_cell_classifier #(.CELL_TICKS(CELL_TICKS), .CNT_W(CNT_W)) u_cls (
        .ivl(ivl), .cells(cells), .over(over)
    );

    dsep_bit_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .mfm_sel(mfm_sel),
        .ivl_stb(ivl_stb), .cells(cells), .over(over), .slot_par(slot_par),
        .dbit(dbit), .dbit_valid(dbit_valid),
        .data_window(data_window), .interval_err(interval_err)
    );

    // R3: every burst of bits starts right after an interval event
    p_bits_follow_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbit_valid) |-> $past(ivl_stb));
endmodule

// File: tb/dsep_data_separator_tb.sv
`timescale 1ns/1ps
module dsep_data_separator_tb;
    localparam int CELL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mfm_sel = 1'b1;
    logic rd_flux = 1'b0;
    logic dbit, dbit_valid, data_window, interval_err;

    int checks = 0;
    int failures = 0;
    int err_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 1'b0;
    bit got_q[$];

    always #2.5 clk = ~clk;

    dsep_data_separator #(.CELL_TICKS(CELL)) u_dut (
        .clk(clk), .rst_n(rst_n), .mfm_sel(mfm_sel), .rd_flux(rd_flux),
        .dbit(dbit), .dbit_valid(dbit_valid),
        .data_window(data_window), .interval_err(interval_err)
    );

    // Collect decoded bits and error strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dbit_valid) begin
                got_q.push_back(dbit);
                run_len++;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
            end
            if (interval_err) err_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        mfm_sel = mode;
        rd_flux = 1'b0;
        repeat (4) @(negedge clk);
        got_q.delete();
        err_cnt = 0;
        run_len = 0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_gap(input int hold, input int gap);
        rd_flux = 1'b1;
        repeat (hold) @(negedge clk);
        rd_flux = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic cmp_bits(input string req, input bit e[$]);
        int first_bad = -1;
        chk(got_q.size() == e.size(), req, "bit count", got_q.size(), e.size());
        for (int i = 0; i < e.size(); i++)
            if (i < got_q.size() && first_bad < 0 && got_q[i] != e[i]) first_bad = i;
        chk(first_bad < 0, req, "first mismatching bit index", first_bad, -1);
    endtask

    // Replay a list of slot positions as pulses, per ticks per slot.
    task automatic drive_slots(input int slots[$], input int per, input int jit);
        int t_prev = slots[0] * per;
        for (int k = 1; k < slots.size(); k++) begin
            int j = (jit > 0) ? int'($urandom_range(2*jit, 0)) - jit : 0;
            int t = slots[k] * per + j;
            pulse_gap(2, t - t_prev - 2);
            t_prev = t;
        end
        pulse_gap(2, 40);
    endtask

    // Expected MFM stream: bits after a leading 1, ended by a 1 (R3).
    task automatic run_mfm(input string req, input int per, input int jit, input int nb);
        bit b[$];
        bit e[$];
        int slots[$];
        do_reset(1'b1);
        b.push_back(1'b1);
        for (int i = 1; i < nb; i++) b.push_back(1'($urandom_range(1, 0)));
        b.push_back(1'b1);
        slots.push_back(1);
        for (int i = 1; i <= nb; i++) begin
            if (!(b[i-1] | b[i])) slots.push_back(2*i);
            if (b[i]) slots.push_back(2*i+1);
            e.push_back(b[i]);
        end
        drive_slots(slots, per, jit);
        cmp_bits(req, e);
        chk(err_cnt == 0, req, "error strobes on legal MFM", err_cnt, 0);
    endtask

    // Expected FM stream: every data bit, closed by a final clock (R4).
    task automatic run_fm(input string req, input int per, input int jit, input int nb);
        bit b[$];
        bit e[$];
        int slots[$];
        do_reset(1'b0);
        for (int i = 0; i < nb; i++) b.push_back(1'($urandom_range(1, 0)));
        for (int i = 0; i < nb; i++) begin
            slots.push_back(2*i);
            if (b[i]) slots.push_back(2*i+1);
            e.push_back(b[i]);
        end
        slots.push_back(2*nb);
        drive_slots(slots, per, jit);
        cmp_bits(req, e);
        chk(err_cnt == 0, req, "error strobes on legal FM", err_cnt, 0);
    endtask

    initial begin
        int unsigned seed_v;
        bit e[$];
        seed_v = $urandom(32'd2024);

        // R11: reset state
        do_reset(1'b1);
        chk(dbit_valid == 1'b0, "R11", "dbit_valid after reset", dbit_valid, 0);
        chk(interval_err == 1'b0, "R11", "interval_err after reset", interval_err, 0);
        chk(data_window == 1'b1, "R11", "data_window after reset", data_window, 1);

        // R10: window phase around a reference pulse in MFM
        rd_flux = 1'b1;
        repeat (2) @(negedge clk);
        rd_flux = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_window == 1'b1, "R10", "window early in cell", data_window, 1);
        repeat (7) @(negedge clk);
        chk(data_window == 1'b0, "R10", "window one cell later", data_window, 0);
        repeat (10) @(negedge clk);
        chk(data_window == 1'b1, "R10", "window two cells later", data_window, 1);
        chk(got_q.size() == 0 && err_cnt == 0, "R5", "reference pulse output",
            got_q.size() + err_cnt, 0);
        do_reset(1'b0);
        rd_flux = 1'b1;
        repeat (2) @(negedge clk);
        rd_flux = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_window == 1'b0, "R10", "FM window early in cell", data_window, 0);

        // R3, R4: random streams at nominal speed with jitter
        run_mfm("R3", CELL, 2, 40);
        run_mfm("R3", CELL, 2, 40);
        run_fm("R4", CELL, 2, 40);

        // R8: spindle 10 % fast and slow
        run_mfm("R8", CELL-1, 1, 40);
        run_mfm("R8", CELL+1, 0, 40);
        run_fm("R8", CELL-1, 1, 40);
        run_fm("R8", CELL+1, 1, 40);

        // R6: very long gap, then recovery from a fresh data-slot reference
        do_reset(1'b1);
        pulse_gap(2, 58);
        pulse_gap(2, 18);
        pulse_gap(2, 30);
        chk(err_cnt == 1, "R6", "errors after long gap", err_cnt, 1);
        e = '{1'b1};
        cmp_bits("R6", e);

        // R7: MFM spacing under 1.5 cells
        do_reset(1'b1);
        pulse_gap(2, 8);
        pulse_gap(2, 30);
        chk(err_cnt == 1, "R7", "errors on short MFM gap", err_cnt, 1);
        chk(got_q.size() == 0, "R7", "bits on short MFM gap", got_q.size(), 0);

        // R7: four cells after a clock slot in MFM
        do_reset(1'b1);
        pulse_gap(2, 28);
        pulse_gap(2, 38);
        pulse_gap(2, 30);
        chk(err_cnt == 1, "R7", "errors on clock+4 MFM", err_cnt, 1);
        e = '{1'b0};
        cmp_bits("R7", e);

        // R7: two cells after a data slot in FM
        do_reset(1'b0);
        pulse_gap(2, 8);
        pulse_gap(2, 18);
        pulse_gap(2, 30);
        chk(err_cnt == 1, "R7", "errors on data+2 FM", err_cnt, 1);
        e = '{1'b1};
        cmp_bits("R7", e);

        // R4: one cell after a data slot in FM emits nothing
        do_reset(1'b0);
        pulse_gap(2, 8);
        pulse_gap(2, 8);
        pulse_gap(2, 6);
        chk(got_q.size() == 1, "R4", "bits after data+1 FM", got_q.size(), 1);
        repeat (12) @(negedge clk);
        pulse_gap(2, 30);
        e = '{1'b1, 1'b0};
        cmp_bits("R4", e);
        chk(err_cnt == 0, "R4", "errors in FM data+1 case", err_cnt, 0);

        // R1: a wide input pulse counts once
        do_reset(1'b1);
        pulse_gap(15, 5);
        pulse_gap(2, 30);
        e = '{1'b1};
        cmp_bits("R1", e);
        chk(err_cnt == 0, "R1", "errors for wide pulse", err_cnt, 0);

        // R2: MFM thresholds at 2.5 cells
        do_reset(1'b1);
        pulse_gap(2, 22);
        pulse_gap(2, 23);
        pulse_gap(2, 30);
        e = '{1'b1, 1'b0};
        cmp_bits("R2", e);

        // R2, R6: 4.4 cells is four cells, 4.5 cells is over
        do_reset(1'b1);
        pulse_gap(2, 42);
        pulse_gap(2, 43);
        pulse_gap(2, 30);
        e = '{1'b0, 1'b1};
        cmp_bits("R2", e);
        chk(err_cnt == 1, "R6", "errors at 4.5 cells", err_cnt, 1);

        // R2, R6: FM thresholds at 1.5 and 2.5 cells
        do_reset(1'b0);
        pulse_gap(2, 12);
        pulse_gap(2, 12);
        pulse_gap(2, 13);
        pulse_gap(2, 22);
        pulse_gap(2, 23);
        pulse_gap(2, 30);
        e = '{1'b1, 1'b0, 1'b0};
        cmp_bits("R2", e);
        chk(err_cnt == 1, "R6", "errors at 2.5 cells FM", err_cnt, 1);

        // R9: bursts reach two bits and never more
        chk(max_run == 2, "R9", "longest dbit_valid run", max_run, 2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule